// File: doc/BRIEF.md
# Channel-Zero Message Extraction Unit

This block sits beside a PCM switching core that serves eight serial input buses. Once per frame, the core hands over the byte found in timeslot 0 of each bus. The unit keeps the bytes that come from enabled buses and that are relevant. A byte is relevant when its top two bits are anything other than `01`. At a frame boundary, the unit signals a host microprocessor that messages are waiting. The host then drains them one bus at a time. The highest-numbered bus comes first and the order runs downward.

The host reaches the unit through a small byte port. The port has a chip select, write and read strobes, and a command/data selector. The host stores an 8-bit bus-enable mask with a three-byte sequence. It reads a message register and a status register.

While the host drains a set of messages, new channel-0 bytes collect in a background store. The background store joins the pending set at the first frame boundary after the drain ends. No byte is lost and no byte is delivered twice. For each bus, the newest relevant byte is the one kept.

The channel-0 inputs carry a valid strobe and have no ready signal. The unit never applies back-pressure: it accepts every valid byte in the cycle it appears.

Top module: `ch0_extract`

## Requirements
- R1: After reset, `dr_n` is 1, extraction is off, and a status read returns 8'h0E.
- R2: The mask is stored by three writes:
  - a command write (`cd`=1) of opcode 8'h06;
  - a data write (`cd`=0) whose bits [2:0] become mask bits 7..5;
  - a data write whose bits [4:0] become mask bits 4..0.
  
  After the store, the status reads `{ones(mask) mod 8 in [7:5], mask!=0 in [4], 4'b1110}`, and the pending and background sets are empty.
- R3: Storing an all-zero mask turns extraction off. This also cancels a drain in progress, so `dr_n` returns to 1 on the next cycle. After that, no byte is captured and no frame boundary asserts `dr_n`.
- R4: A channel-0 byte whose bits [7:6] equal 2'b01 is never captured and never causes `dr_n` to go low.
- R5: A relevant byte with `ch0_vld[i]`=1 is captured only when mask bit i is 1. At a `frame_end` cycle with no drain in progress and at least one captured byte, `dr_n` goes low right after that clock edge.
- R6: The first status read after `dr_n` falls returns `{count mod 8 in [7:5], 1 in [4], 4'b1110}`, where count is the number of pending buses.
- R7: After that header, each message read (`cd`=0) returns the byte of the highest-numbered pending bus. Each status read returns `{bus in [7:5], Fn in [4], 4'b1110}` and then moves on to the next lower pending bus.
- R8: Fn is 1 while more pending buses remain and 0 on the last one. The status read that shows Fn=0 releases `dr_n` to 1 on the next cycle.
- R9: Bytes captured while a drain is in progress stay in the background store, keeping the newest byte per bus. A `frame_end` during the drain does not merge them. They are delivered after the next `frame_end` that follows the end of the drain.
- R10: A data write with no opcode before it, and the data bytes that follow any opcode other than 8'h06, leave the mask and the status unchanged.
- R11: A byte whose valid strobe falls in the same cycle as `frame_end` belongs to the next frame: it is not part of the set that this `frame_end` releases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch0_vld | input | 8 | Per-bus valid strobe for the channel-0 byte |
| ch0_data | input | 64 | Channel-0 bytes, bus i at bits [8i+7:8i] |
| frame_end | input | 1 | One-cycle pulse that marks a frame boundary |
| cs_n | input | 1 | Host chip select, active low |
| wr_n | input | 1 | Host write strobe, active low |
| rd_n | input | 1 | Host read strobe, active low |
| cd | input | 1 | 1 selects command/status, 0 selects data/message |
| din | input | 8 | Host write data |
| dout | output | 8 | Host read data; 0 when no read is active |
| dr_n | output | 1 | Data ready, active low |

## Verification
The main function is exercised with three kinds of frames:
- A mixed frame contains enabled buses, disabled buses and a `01`-labelled byte. It separates mask gating from relevance filtering, and shows the downward order through the message and status pairs.
- A frame with every bus enabled drives the pending count to eight. This exposes the modulo-8 wrap of the count with Tn still at 1.
- Bytes injected during a drain, including two bytes for the same bus, show whether the background store keeps the newest byte and holds it until the drain ends.

Further cases cover a byte that coincides with `frame_end`, stray and foreign-opcode writes, and a null mask stored in the middle of a drain. These show where each path can leak a byte or a mask change.

// File: rtl/ch0x_pkg.sv
package ch0x_pkg;
  localparam int NBUS = 8;
  localparam int MW   = 8;
  localparam int BUSW = $clog2(NBUS);
  localparam int LOW  = 5;
  localparam logic [7:0] OP_MASK = 8'h06;
  localparam logic [3:0] ST_TAIL = 4'b1110;
  localparam logic [1:0] LBL_SKIP = 2'b01;
  typedef enum logic [1:0] {SQ_IDLE, SQ_HI, SQ_LO} seq_t;
endpackage

// File: rtl/ch0x_capture.sv
module ch0x_capture
  import ch0x_pkg::*;
#(
  parameter int N = NBUS,
  parameter int W = MW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           take,
  input  logic [N-1:0]   en,
  input  logic [N-1:0]   vld,
  input  logic [N*W-1:0] data,
  output logic [N-1:0]   bg_pend,
  output logic [N*W-1:0] bg_msg
);
  for (genvar i = 0; i < N; i++) begin : g_bus
    logic [W-1:0] byte_i;
    logic         rel;
    assign byte_i = data[i*W +: W];
    assign rel    = byte_i[W-1 -: 2] != LBL_SKIP;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bg_pend[i]       <= 1'b0;
        bg_msg[i*W +: W] <= '0;
      end else if (clr) begin
        bg_pend[i] <= 1'b0;
      end else if (vld[i] && en[i] && rel) begin
        bg_pend[i]       <= 1'b1;
        bg_msg[i*W +: W] <= byte_i;
      end else if (take) begin
        bg_pend[i] <= 1'b0;
      end
    end

    p_skip_label_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (vld[i] && !rel && !take && !clr) |=> bg_pend[i] == $past(bg_pend[i]));
    p_off_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!en[i] && !bg_pend[i]) |=> !bg_pend[i]);
  end
endmodule

// File: rtl/ch0x_scan.sv
module ch0x_scan
  import ch0x_pkg::*;
#(
  parameter int N = NBUS,
  parameter int W = MW,
  localparam int BW = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           frame_end,
  input  logic           adv,
  input  logic [N-1:0]   bg_pend,
  input  logic [N*W-1:0] bg_msg,
  output logic           take,
  output logic           busy,
  output logic           hdr,
  output logic [BW-1:0]  cursor,
  output logic           more,
  output logic [BW:0]    cnt,
  output logic [W-1:0]   cur_msg
);
  logic [N-1:0]   pend;
  logic [N*W-1:0] msgs;

  always_comb begin
    cursor = '0;
    cnt    = '0;
    for (int i = 0; i < N; i++) begin
      if (pend[i]) begin
        cursor = BW'(i);
        cnt    = cnt + 1'b1;
      end
    end
  end

  assign busy    = |pend;
  assign more    = cnt > 1;
  assign take    = frame_end && !busy && (|bg_pend);
  assign cur_msg = msgs[cursor*W +: W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      msgs <= '0;
      hdr  <= 1'b0;
    end else if (clr) begin
      pend <= '0;
      hdr  <= 1'b0;
    end else if (take) begin
      pend <= bg_pend;
      msgs <= bg_msg;
      hdr  <= 1'b1;
    end else if (adv && busy) begin
      if (hdr) hdr <= 1'b0;
      else     pend[cursor] <= 1'b0;
    end
  end

  p_last_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && busy && !hdr && !more && !clr) |=> !busy);
  p_desc_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && busy && !hdr && more && !clr) |=> busy && cursor < $past(cursor));
  p_bg_waits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !clr && !adv) |=> $stable(pend));
endmodule

// File: rtl/ch0x_host.sv
module ch0x_host
  import ch0x_pkg::*;
#(
  parameter int N = NBUS,
  parameter int W = MW,
  localparam int BW  = $clog2(N),
  localparam int HIW = N - LOW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         wr_n,
  input  logic         rd_n,
  input  logic         cd,
  input  logic [W-1:0] din,
  output logic         rd,
  output logic         clr,
  output logic [N-1:0] mask,
  output logic [W-1:0] stat_hold
);
  seq_t           seq;
  logic           wr;
  logic [HIW-1:0] hi;
  logic [N-1:0]   new_mask;
  logic [BW:0]    ones;

  assign wr       = !cs_n && !wr_n && rd_n;
  assign rd       = !cs_n && !rd_n && wr_n;
  assign clr      = wr && !cd && seq == SQ_LO;
  assign new_mask = {hi, din[LOW-1:0]};

  always_comb begin
    ones = '0;
    for (int i = 0; i < N; i++) ones = ones + (BW+1)'(new_mask[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq       <= SQ_IDLE;
      hi        <= '0;
      mask      <= '0;
      stat_hold <= {{BW{1'b0}}, 1'b0, ST_TAIL};
    end else if (wr && cd) begin
      seq <= (din == OP_MASK) ? SQ_HI : SQ_IDLE;
    end else if (wr) begin
      case (seq)
        SQ_HI: begin
          hi  <= din[HIW-1:0];
          seq <= SQ_LO;
        end
        SQ_LO: begin
          mask      <= new_mask;
          stat_hold <= {ones[BW-1:0], |new_mask, ST_TAIL};
          seq       <= SQ_IDLE;
        end
        default: seq <= SQ_IDLE;
      endcase
    end
  end

  p_null_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && hi == '0 && din[LOW-1:0] == '0) |=> mask == '0 && !stat_hold[4]);
  p_stray_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !cd && seq == SQ_IDLE) |=> $stable(mask) && $stable(stat_hold));
endmodule

// File: rtl/ch0_extract.sv
module ch0_extract
  import ch0x_pkg::*;
#(
  parameter int N = NBUS,
  parameter int W = MW,
  localparam int BW = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   ch0_vld,
  input  logic [N*W-1:0] ch0_data,
  input  logic           frame_end,
  input  logic           cs_n,
  input  logic           wr_n,
  input  logic           rd_n,
  input  logic           cd,
  input  logic [W-1:0]   din,
  output logic [W-1:0]   dout,
  output logic           dr_n
);
  logic           rd, clr, take, busy, hdr, more;
  logic [N-1:0]   mask, bg_pend;
  logic [N*W-1:0] bg_msg;
  logic [W-1:0]   stat_hold, cur_msg, status, message;
  logic [BW-1:0]  cursor;
  logic [BW:0]    cnt;

  ch0x_host #(.N(N), .W(W)) u_host (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .cd(cd), .din(din), .rd(rd), .clr(clr), .mask(mask),
    .stat_hold(stat_hold)
  );

  ch0x_capture #(.N(N), .W(W)) u_cap (
    .clk(clk), .rst_n(rst_n), .clr(clr), .take(take), .en(mask),
    .vld(ch0_vld), .data(ch0_data), .bg_pend(bg_pend), .bg_msg(bg_msg)
  );

  ch0x_scan #(.N(N), .W(W)) u_scan (
    .clk(clk), .rst_n(rst_n), .clr(clr), .frame_end(frame_end),
    .adv(rd && cd), .bg_pend(bg_pend), .bg_msg(bg_msg), .take(take),
    .busy(busy), .hdr(hdr), .cursor(cursor), .more(more), .cnt(cnt),
    .cur_msg(cur_msg)
  );

  always_comb begin
    if (!busy)    status = stat_hold;
    else if (hdr) status = {cnt[BW-1:0], 1'b1, ST_TAIL};
    else          status = {cursor, more, ST_TAIL};
  end

  assign message = (busy && !hdr) ? cur_msg : '0;
  assign dout    = rd ? (cd ? status : message) : '0;
  assign dr_n    = !busy;

  p_dr_on_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !clr) |=> !dr_n);
  p_clr_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> dr_n);
endmodule

// File: tb/ch0_extract_tb.sv
module ch0_extract_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  ch0_vld = '0;
  logic [63:0] ch0_data = '0;
  logic        frame_end = 1'b0;
  logic        cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, cd = 1'b0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        dr_n;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  ch0_extract u_dut (
    .clk(clk), .rst_n(rst_n), .ch0_vld(ch0_vld), .ch0_data(ch0_data),
    .frame_end(frame_end), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .cd(cd), .din(din), .dout(dout), .dr_n(dr_n)
  );

  // Behavioural reference for the data-ready line
  logic [7:0] m_mask, m_bgv, m_pend;
  logic [7:0] m_bg [8];
  logic [2:0] m_hi;
  bit         m_hdr, m_take, m_w, m_r, m_clr;
  int         m_seq, m_top;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mask = '0; m_bgv = '0; m_pend = '0; m_hdr = 0; m_seq = 0; m_hi = '0;
    end else begin
      m_w = !cs_n && !wr_n && rd_n;
      m_r = !cs_n && !rd_n && wr_n;
      m_clr = 0;
      m_top = 0;
      for (int i = 0; i < 8; i++) if (m_pend[i]) m_top = i;
      m_take = frame_end && m_pend == 0 && m_bgv != 0;
      if (m_take) begin
        m_pend = m_bgv; m_hdr = 1; m_bgv = '0;
      end else if (m_r && cd && m_pend != 0) begin
        if (m_hdr) m_hdr = 0; else m_pend[m_top] = 1'b0;
      end
      for (int i = 0; i < 8; i++)
        if (ch0_vld[i] && m_mask[i] && ch0_data[i*8+6 +: 2] != 2'b01) begin
          m_bgv[i] = 1'b1; m_bg[i] = ch0_data[i*8 +: 8];
        end
      if (m_w && cd) m_seq = (din == 8'h06) ? 1 : 0;
      else if (m_w) begin
        if (m_seq == 1) begin m_hi = din[2:0]; m_seq = 2; end
        else if (m_seq == 2) begin
          m_mask = {m_hi, din[4:0]}; m_clr = 1; m_seq = 0;
        end
      end
      if (m_clr) begin m_pend = '0; m_bgv = '0; m_hdr = 0; end
    end
  end

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) check("R5 dr_n vs model", {7'd0, dr_n}, {7'd0, m_pend == 0});

  task automatic wr_byte(input logic c, input logic [7:0] b);
    @(negedge clk); cs_n = 0; wr_n = 0; cd = c; din = b;
    @(negedge clk); cs_n = 1; wr_n = 1;
  endtask

  task automatic rd_chk(input logic c, input logic [7:0] exp, input string tag);
    @(negedge clk); cs_n = 0; rd_n = 0; cd = c;
    #1 check(tag, dout, exp);
    @(negedge clk); cs_n = 1; rd_n = 1;
  endtask

  task automatic put_mask(input logic [7:0] m);
    wr_byte(1, 8'h06); wr_byte(0, {5'd0, m[7:5]}); wr_byte(0, {3'd0, m[4:0]});
  endtask

  task automatic capture(input logic [7:0] v, input logic [63:0] d, input logic fe);
    @(negedge clk); ch0_vld = v; ch0_data = d; frame_end = fe;
    @(negedge clk); ch0_vld = '0; frame_end = 0;
  endtask

  task automatic fend();
    capture(8'h00, 64'h0, 1'b1);
  endtask

  function automatic logic [63:0] fill(input logic [7:0] base);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[i*8 +: 8] = base + 8'(i);
    return r;
  endfunction

  initial begin
    logic [63:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 dr_n reset", {7'd0, dr_n}, 8'h01);
    rd_chk(1, 8'h0E, "R1 status reset");

    put_mask(8'hA5);
    rd_chk(1, 8'h9E, "R2 status after mask A5");
    wr_byte(0, 8'h1F);
    wr_byte(1, 8'h33); wr_byte(0, 8'h00); wr_byte(0, 8'h00);
    rd_chk(1, 8'h9E, "R10 stray writes ignored");

    d = fill(8'h80); d[5*8 +: 8] = 8'h45;
    capture(8'hFF, d, 0);
    fend();
    check("R5 dr low after frame", {7'd0, dr_n}, 8'h00);
    rd_chk(1, 8'h7E, "R6 header count 3");
    rd_chk(0, 8'h87, "R7 msg bus7");
    capture(8'h80, {8'hC1, 56'h0}, 0);
    capture(8'h80, {8'hC2, 56'h0}, 0);
    fend();
    rd_chk(1, 8'hFE, "R7 status bus7 Fn1");
    rd_chk(0, 8'h82, "R7 msg bus2");
    rd_chk(1, 8'h5E, "R7 status bus2 Fn1");
    rd_chk(0, 8'h80, "R7 msg bus0");
    rd_chk(1, 8'h0E, "R8 status bus0 Fn0");
    check("R8 dr released", {7'd0, dr_n}, 8'h01);
    fend();
    rd_chk(1, 8'h3E, "R9 header count 1");
    rd_chk(0, 8'hC2, "R9 newest bg byte");
    rd_chk(1, 8'hEE, "R9 status bus7 last");
    check("R9 dr released", {7'd0, dr_n}, 8'h01);

    capture(8'hFF, fill(8'h50), 0);
    fend();
    check("R4 01 label ignored", {7'd0, dr_n}, 8'h01);

    capture(8'h01, {56'h0, 8'h90}, 1);
    check("R11 same-cycle byte waits", {7'd0, dr_n}, 8'h01);
    fend();
    rd_chk(1, 8'h3E, "R11 header");
    rd_chk(0, 8'h90, "R11 msg");
    rd_chk(1, 8'h0E, "R11 last");

    put_mask(8'hFF);
    rd_chk(1, 8'h1E, "R2 status mask FF wraps");
    capture(8'hFF, fill(8'hA0), 0);
    fend();
    rd_chk(1, 8'h1E, "R6 header count 8 wraps");
    rd_chk(0, 8'hA7, "R7 msg bus7 of 8");
    put_mask(8'h00);
    check("R3 null cancels drain", {7'd0, dr_n}, 8'h01);
    rd_chk(1, 8'h0E, "R3 status null");
    capture(8'hFF, fill(8'hA0), 0);
    fend();
    check("R3 no capture when off", {7'd0, dr_n}, 8'h01);

    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog got=hung exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule